// File: doc/BRIEF.md
# Configurable Audio Serial Transmitter

This block sends multi-channel PCM samples out on a single serial data line. Each channel holds one 32-bit sample on a parallel input, and the block sends it MSB first. A 16-bit configuration word selects stereo or time-division-multiplexed framing. It also sets the frame-sync shape and polarity, which bit-clock edge launches data, the MSB delay and the word length.

As clock master, the block divides the system clock to make its own bit clock and frame sync, and it raises an output-enable to show that the clock pins are driven. As slave, it resynchronises an external bit clock and frame sync and follows them. The data and sync outputs change only on the launch edge of the bit clock. A receiver samples them on the opposite edge.

Top module: `tdm_serial_tx`

## Requirements
- R1: Under reset the port is slave: `clk_oe_o`, `bclk_o`, `lrck_o` and `sdo_o` are all 0 while `ctrl_i[11]` is 0.
- R2: With `ctrl_i[11]`=1 (master), `clk_oe_o` is 1 and `bclk_o` toggles every 2<<`ctrl_i[10:9]` system clocks (2, 4, 8 or 16).
- R3: `sdo_o` and `lrck_o` change only on the launch edge of the bit clock: the falling edge when `ctrl_i[12]`=0 and the rising edge when it is 1.
- R4: In master mode a frame lasts 64<<`ctrl_i[8:7]` bit clocks. With a word-clock sync (`ctrl_i[6]`=0), the sync sits at level `ctrl_i[13]` for the first half of the frame and at the other level for the second half. In stereo framing (`ctrl_i[5]`=0), channel 0 is sent in the first half and channel 1 in the second, each from the start of its half.
- R5: With a pulse sync (`ctrl_i[6]`=1), the sync sits at level `ctrl_i[13]` for the first bit clock of the frame only. Channel k then starts at bit clock 32k of the frame, and this holds in stereo framing as well.
- R6: With `ctrl_i[5]`=1 (TDM), channel k occupies the 32-bit-clock slot k. There are 8 channels when `ctrl_i[14]`=0 and 16 when it is 1. Slots past the channel count are all zero, and channels that do not fit in the frame are not sent.
- R7: Within its slot or half-frame, the MSB (bit 31 of the channel's sample) goes out after `ctrl_i[4:2]` bit clocks (0 to 7), followed by the lower bits in descending order.
- R8: `ctrl_i[1:0]` sets the word length: 00=24, 01=20, 10=16 and 11=32 bits. Every bit clock after the LSB carries 0, and bits that the delay pushes past the end of a TDM or pulse slot are dropped.
- R9: In slave mode the port follows `bclk_i` and `lrck_i`, and its clock outputs stay low. A sync transition into level `ctrl_i[13]` starts a frame. In stereo word-clock framing, the opposite transition starts channel 1.
- R10: `ctrl_i[15]` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| ctrl_i | input | 16 | configuration word |
| samples_i | input | 512 | sixteen 32-bit channel samples, channel k at bits [32k+31:32k] |
| bclk_i | input | 1 | external bit clock (slave) |
| lrck_i | input | 1 | external frame sync (slave) |
| bclk_o | output | 1 | generated bit clock (master) |
| lrck_o | output | 1 | generated frame sync (master) |
| clk_oe_o | output | 1 | clock pins are driven (master) |
| sdo_o | output | 1 | serial data |

## Verification
The stream is captured on the receiving edge. It is compared bit by bit, over two whole frames, with a model of the requirements. Several stereo cases cross both sync polarities with both launch edges, so a swapped channel or a wrong edge shows. Separate cases use long and short words and the largest MSB delay, which shows truncation and zero fill. TDM cases use frames that are too long and too short for the channel count, which exposes slot indexing and empty-slot errors. Two slave runs driven from external clocks, one with a word clock and one with a pulse, check frame-start detection and the start of the right channel.

// File: rtl/tdm_serial_tx.sv
module tdm_serial_tx #(
  parameter int DIV_BASE = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [15:0]  ctrl_i,
  input  logic [511:0] samples_i,
  input  logic         bclk_i,
  input  logic         lrck_i,
  output logic         bclk_o,
  output logic         lrck_o,
  output logic         clk_oe_o,
  output logic         sdo_o
);
  localparam int SWB = 5;
  localparam int CHW = 4;
  localparam int CW  = CHW + SWB;

  logic       tdm16, spol, bpol, master, pulse, tdm;
  logic [1:0] bsel, fsel, wsel;
  logic [2:0] dly;
  assign {tdm16, spol, bpol, master, bsel, fsel, pulse, tdm, dly, wsel} = ctrl_i[14:0];

  logic [7:0]  hp;
  logic [9:0]  flen, half;
  logic [5:0]  wlen;
  logic [4:0]  nsl;
  assign hp   = 8'(DIV_BASE) << bsel;
  assign flen = 10'd64 << fsel;
  assign half = flen >> 1;
  assign nsl  = tdm ? (tdm16 ? 5'd16 : 5'd8) : 5'd2;
  always_comb
    case (wsel)
      2'd0:    wlen = 6'd24;
      2'd1:    wlen = 6'd20;
      2'd2:    wlen = 6'd16;
      default: wlen = 6'd32;
    endcase

  logic [7:0] div_q;
  logic       bclk_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!master) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (div_q == hp - 8'd1) begin
      div_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      div_q  <= div_q + 8'd1;
    end

  logic [2:0] bck_s;
  logic [1:0] lr_s;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bck_s <= '0;
      lr_s  <= '0;
    end else begin
      bck_s <= {bck_s[1:0], bclk_i};
      lr_s  <= {lr_s[0], lrck_i};
    end

  logic lrck_now, m_launch, s_launch, launch;
  assign lrck_now = lr_s[1];
  assign m_launch = master && (div_q == hp - 8'd1) && (bclk_q != bpol);
  assign s_launch = !master && (bck_s[2] != bck_s[1]) && (bck_s[1] == bpol);
  assign launch   = m_launch || s_launch;

  logic [CW-1:0] cnt_q, hcnt_q, cnt_n, hcnt_n, pos, off;
  logic          lr_last, right_n, sync_n, sdo_n, valid;
  logic [4:0]    ch;

  always_comb begin
    if (master) begin
      cnt_n   = ({1'b0, cnt_q} >= flen - 10'd1) ? '0 : cnt_q + 1'b1;
      right_n = {1'b0, cnt_n} >= half;
      hcnt_n  = right_n ? cnt_n - half[CW-1:0] : cnt_n;
    end else begin
      cnt_n   = (lrck_now == spol && lr_last != spol) ? '0 :
                (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      hcnt_n  = (lrck_now != lr_last) ? '0 : (&hcnt_q) ? hcnt_q : hcnt_q + 1'b1;
      right_n = lrck_now != spol;
    end
    if (tdm || pulse) begin
      ch  = {1'b0, cnt_n[CW-1:SWB]};
      pos = {{CHW{1'b0}}, cnt_n[SWB-1:0]};
    end else begin
      ch  = {4'b0, right_n};
      pos = hcnt_n;
    end
    off    = pos - CW'(dly);
    valid  = (ch < nsl) && (pos >= CW'(dly)) && (off < CW'(wlen));
    sdo_n  = valid && samples_i[{ch[CHW-1:0], ~off[SWB-1:0]}];
    sync_n = pulse ? ((cnt_n == '0) ? spol : ~spol) : (right_n ? ~spol : spol);
  end

  logic sdo_q, lrck_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q   <= '1;
      hcnt_q  <= '1;
      sdo_q   <= 1'b0;
      lrck_q  <= 1'b0;
      lr_last <= 1'b0;
    end else if (launch) begin
      cnt_q   <= cnt_n;
      hcnt_q  <= hcnt_n;
      sdo_q   <= sdo_n;
      lrck_q  <= sync_n;
      lr_last <= lrck_now;
    end

  assign bclk_o   = bclk_q;
  assign lrck_o   = master && lrck_q;
  assign clk_oe_o = master;
  assign sdo_o    = sdo_q;
endmodule

// File: rtl/tdm_serial_tx_chk.sv
module tdm_serial_tx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] ctrl_i,
  input logic        bclk_o,
  input logic        lrck_o,
  input logic        clk_oe_o,
  input logic        sdo_o
);
  AST_SDO_HOLDS_BETWEEN_LAUNCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[11] && ctrl_i == $past(ctrl_i) && bclk_o == $past(bclk_o)) |-> sdo_o == $past(sdo_o)); // R3

  AST_SYNC_MOVES_ON_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[11] && ctrl_i == $past(ctrl_i) && lrck_o != $past(lrck_o))
      |-> (bclk_o != $past(bclk_o) && bclk_o == ctrl_i[12])); // R3

  AST_BCLK_MIN_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[11] && ctrl_i == $past(ctrl_i) && bclk_o != $past(bclk_o)) |=> $stable(bclk_o)); // R2

  AST_SLAVE_CLOCKS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[11] |-> (!clk_oe_o && !bclk_o && !lrck_o)); // R9
endmodule

bind tdm_serial_tx tdm_serial_tx_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i), .bclk_o(bclk_o),
  .lrck_o(lrck_o), .clk_oe_o(clk_oe_o), .sdo_o(sdo_o)
);

// File: tb/tdm_serial_tx_tb_top.sv
`timescale 1ns/1ps
module tdm_serial_tx_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  ctrl = '0;
  logic [511:0] samples = '0;
  logic         bclk_i = 1'b0, lrck_i = 1'b0;
  logic         bclk_o, lrck_o, clk_oe_o, sdo_o;

  always #2 clk = ~clk;

  tdm_serial_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .samples_i(samples),
    .bclk_i(bclk_i), .lrck_i(lrck_i), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .clk_oe_o(clk_oe_o), .sdo_o(sdo_o)
  );

  typedef struct { logic lr; logic d; logic chk_lr; int k; } item_t;
  item_t exp_q[$];
  int    checks = 0, errors = 0;
  string cur_tag = "R1";
  logic  cur_bpol = 1'b0, seen = 1'b0, prev_src = 1'b0;
  int    hp_cnt = 0, last_hp = 0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] samp(input int t, input int c);
    return 32'hA5C3_0F96 ^ (32'(c) * 32'h1357_9BDF) ^ (32'(t) << 7);
  endfunction

  function automatic logic [15:0] mk(input bit t16, spol, bpol, ms, input int bs, fs,
                                     input bit pul, td, input int d, w);
    return {1'b0, t16, spol, bpol, ms, 2'(bs), 2'(fs), pul, td, 3'(d), 2'(w)};
  endfunction

  function automatic item_t model(input logic [15:0] c, input int flen, input int k, input int t);
    item_t it;
    int n, half, ch, pos, d, w;
    logic s;
    s = c[13]; half = flen / 2;
    n = c[5] ? (c[14] ? 16 : 8) : 2;
    d = int'(c[4:2]);
    case (c[1:0]) 2'd0: w = 24; 2'd1: w = 20; 2'd2: w = 16; default: w = 32; endcase
    it.lr = c[6] ? ((k == 0) ? s : !s) : ((k < half) ? s : !s);
    if (c[5] || c[6]) begin ch = k / 32; pos = k % 32; end
    else begin ch = (k >= half) ? 1 : 0; pos = k - ch * half; end
    it.d = 1'b0;
    if (ch < n && pos >= d && pos - d < w) it.d = samp(t, ch)[31 - (pos - d)];
    it.chk_lr = 1'b1; it.k = k;
    return it;
  endfunction

  always @(negedge clk) begin
    logic src;
    item_t it;
    src = clk_oe_o ? bclk_o : bclk_i;
    hp_cnt++;
    if (src !== prev_src) begin
      if (clk_oe_o) last_hp = hp_cnt;
      hp_cnt = 0;
      if (src == cur_bpol) seen = 1'b1;
      else if (seen && exp_q.size() > 0) begin
        it = exp_q.pop_front();
        check(sdo_o === it.d, $sformatf("data bit %0d", it.k), longint'(sdo_o), longint'(it.d));
        if (it.chk_lr)
          check(lrck_o === it.lr, $sformatf("sync bit %0d", it.k), longint'(lrck_o), longint'(it.lr));
      end
    end
    prev_src = src;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [15:0] c, input int t);
    rst_n = 1'b0;
    ctrl = c;
    for (int i = 0; i < 16; i++) samples[i*32 +: 32] = samp(t, i);
    cur_bpol = c[12];
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic run_master(input logic [15:0] c, input string tag, input int t);
    int flen, wait_n;
    cur_tag = tag;
    seen = 1'b0;
    exp_q.delete();
    flen = 64 << c[8:7];
    load(c, t);
    for (int f = 0; f < 2; f++)
      for (int k = 0; k < flen; k++) exp_q.push_back(model(c, flen, k, t));
    wait_n = 0;
    while (exp_q.size() > 0 && wait_n < 40000) begin tick(1); wait_n++; end
    check(exp_q.size() == 0, "frames completed", exp_q.size(), 0);
    check(clk_oe_o === 1'b1, "R2 output enable", longint'(clk_oe_o), 1);
    check(last_hp == (2 << c[10:9]), "R2 bit clock half period", last_hp, 2 << c[10:9]);
  endtask

  task automatic run_slave(input logic [15:0] c, input int flen, input string tag, input int t);
    item_t it;
    cur_tag = tag;
    seen = 1'b1;
    exp_q.delete();
    bclk_i = ~c[12];
    lrck_i = ~c[13];
    load(c, t);
    for (int b = 0; b < 4 + 2 * flen; b++) begin
      int k;
      k = (b < 4) ? -1 : (b - 4) % flen;
      if (k >= 0) begin it = model(c, flen, k, t); lrck_i = it.lr; end
      tick(1);
      bclk_i = c[12];
      if (k >= 0) begin it.chk_lr = 1'b0; exp_q.push_back(it); end
      check(clk_oe_o === 1'b0 && bclk_o === 1'b0 && lrck_o === 1'b0, "R9 clock outputs quiet",
            {clk_oe_o, bclk_o, lrck_o}, 0);
      tick(8);
      bclk_i = ~c[12];
      tick(7);
    end
    check(exp_q.size() == 0, "R9 frames completed", exp_q.size(), 0);
  endtask

  initial begin
    tick(4);
    check(clk_oe_o === 1'b0, "R1 oe in reset", longint'(clk_oe_o), 0);
    check(bclk_o === 1'b0, "R1 bclk in reset", longint'(bclk_o), 0);
    check(lrck_o === 1'b0, "R1 lrck in reset", longint'(lrck_o), 0);
    check(sdo_o === 1'b0, "R1 sdo in reset", longint'(sdo_o), 0);

    run_master(mk(0,0,0,1,0,0,0,0,1,0), "R2 R3 R4 R7 R8", 1);
    run_master(mk(0,1,1,1,1,1,0,0,0,2), "R2 R3 R4 R8", 2);
    run_master(mk(0,0,0,1,0,0,1,0,7,3), "R5 R7 R8", 3);
    run_master(mk(0,0,1,1,0,2,1,1,3,1), "R5 R6 R7", 4);
    run_master(mk(1,1,0,1,1,3,0,1,2,0) | 16'h8000, "R6 R10", 5);
    run_master(mk(0,0,1,1,0,3,0,1,0,3), "R6 R8", 6);
    run_master(mk(1,0,0,1,0,1,0,1,4,2), "R6", 7);
    run_slave(mk(0,0,0,0,0,0,0,0,1,0), 64, "R9 R4", 8);
    run_slave(mk(0,1,1,0,0,0,1,1,0,2), 256, "R9 R6", 9);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog expired: actual running expected done", cur_tag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule